// File: doc/BRIEF.md
# AU-4 Pointer Interpreter

This block follows the H1/H2 pointer bytes of an AU-4 carried on a byte-wide drop bus and works out where the VC-4 starts. Upstream framing logic supplies one strobe for the H1 byte slot, one for the H2 byte slot, and a strobe for each payload byte slot. It also marks the first payload byte after the pointer area. The block then delivers the J1 offset in bytes, a one-cycle J1 marker, and alarm flags for path AIS and loss of pointer. Three saturating counters record accepted increments, accepted decrements and accepted new-data events.

The pointer word is {H1,H2}. Bits 15:12 are the new-data-flag nibble, bits 11:10 are the size bits and bits 9:0 are the pointer value. Each pointer frame is judged in the cycle that carries the H2 strobe. A three-state machine (normal, AIS, loss of pointer) applies run-length rules to the result. Two configuration inputs adjust the rules: one decides how the size bits are checked, and the other can stop the AIS state from ever falling into loss of pointer. When tracking is switched off, the J1 marker is taken from an external indicator.

Top module: `au4_ptr_interp`

## Requirements
- R1: After reset, lop_alm is 1, ais_alm is 0, offset is 0 and all three counters are 0.
- R2: A valid normal pointer has an NDF nibble within one bit of 0110, accepted size bits and a value of at most 782. Three consecutive valid normal pointers with the same value set offset to 3 times that value and select the normal state. This applies from loss of pointer, AIS or normal. The new value is visible in the cycle after the H2 strobe.
- R3: An NDF nibble within one bit of 1001, with accepted size bits and a value of at most 782, loads the offset at once and adds one to ndf_cnt. This happens in the normal state and also in the AIS state, where it selects normal. In loss of pointer it has no effect.
- R4: In the normal state, a normal pointer is an increment when at least 3 of its I bits (value bits 9,7,5,3,1) differ from the current pointer and fewer than 3 of its D bits (value bits 8,6,4,2,0) differ. An increment adds 1 to the pointer, wrapping 782 to 0, and adds one to pj_cnt. A decrement is the mirror case: it subtracts 1, wrapping 0 to 782, and adds one to nj_cnt.
- R5: An increment or decrement is ignored, leaving the offset and counters unchanged, in each of the three pointer frames that follow an accepted increment, decrement or NDF.
- R6: Eight consecutive invalid pointer frames move the normal state, or the AIS state, to loss of pointer. Eight consecutive frames with an NDF nibble near 1001 also move the normal state to loss of pointer.
- R7: Three consecutive all-ones pointer words move loss of pointer, or normal, to AIS. In AIS, ais_alm is 1 and lop_alm is 0.
- R8: While ais_lop_dis is 1, the AIS state never moves to loss of pointer on invalid frames.
- R9: With ss_chk_en at 0, the size bits are not checked. With ss_chk_en at 1, they must equal 10, or ss_reg when ss_use_reg is 1. A mismatch makes the frame invalid.
- R10: Each counter saturates at 255. A cnt_clr pulse sets a counter to 0, or to 1 when a counted event falls in the same cycle.
- R11: Position 0 is the payload byte strobed together with pay_sof, and each later payload strobe adds one to the position. In the normal state with tracking on, j1_mark is 1 in the cycle after the payload byte whose position equals offset, and only then.
- R12: With track_en at 0, j1_mark follows ext_j1 one cycle later, and pointer frames leave offset unchanged.
- R13: offset changes only in the cycle after a tracked H2 strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| track_en | input | 1 | 1: interpret pointers; 0: use ext_j1 |
| din | input | 8 | Drop bus data byte |
| h1_strb | input | 1 | din holds the H1 byte |
| h2_strb | input | 1 | din holds the H2 byte; frame evaluated |
| pay_strb | input | 1 | din holds a payload byte |
| pay_sof | input | 1 | With pay_strb: payload position 0 |
| ext_j1 | input | 1 | External J1 indicator for untracked mode |
| ss_chk_en | input | 1 | Enable size-bit check |
| ss_use_reg | input | 1 | Compare size bits with ss_reg instead of 10 |
| ss_reg | input | 2 | Programmed size-bit value |
| ais_lop_dis | input | 1 | Block the AIS to loss-of-pointer move |
| cnt_clr | input | 1 | Clear all three event counters |
| offset | output | 12 | J1 offset in bytes |
| j1_mark | output | 1 | J1 position marker |
| ais_alm | output | 1 | Path AIS state |
| lop_alm | output | 1 | Loss-of-pointer state |
| pj_cnt | output | 8 | Accepted increments |
| nj_cnt | output | 8 | Accepted decrements |
| ndf_cnt | output | 8 | Accepted new-data events |

## Verification
A counter clear and a counted event can land in the same cycle. Whether the clear wins or the event survives is the case most easily got wrong. The bench drives cnt_clr in the very cycle that carries the H2 strobe of an accepted NDF frame and expects ndf_cnt to read 1, not 0 or the old count plus one. It also clears without an event, and it drives the counter to saturation with alternating NDF and normal frames, so that all three outcomes of the counter update are compared.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int PTR_W = 10;
  localparam logic [3:0] NDF_ON_PAT  = 4'b1001;
  localparam logic [3:0] NDF_OFF_PAT = 4'b0110;
  localparam logic [1:0] SS_FIXED    = 2'b10;

  typedef enum logic [1:0] {ST_NORM = 2'd0, ST_AIS = 2'd1, ST_LOP = 2'd2} ptr_state_t;

  typedef struct packed {
    logic             ais_pat;   // word is all ones
    logic             ndf_seen;  // NDF nibble near 1001
    logic             ndf_ok;    // NDF with accepted SS and in-range value
    logic             val_ok;    // normal NDF, accepted SS, in range
    logic             inc;
    logic             dec;
    logic [PTR_W-1:0] val;
  } ptr_class_t;
endpackage

// File: rtl/ptr_classify.sv
module ptr_classify
  import ptr_pkg::*;
#(
  parameter int PTR_MAX = 782
) (
  input  logic [15:0]      word,
  input  logic [PTR_W-1:0] cur,
  input  logic             ss_chk_en,
  input  logic             ss_use_reg,
  input  logic [1:0]       ss_reg,
  output ptr_class_t       cls
);
  localparam logic [PTR_W-1:0] MAXV = PTR_W'(PTR_MAX);

  logic [3:0]       nf;
  logic [PTR_W-1:0] v, flip;
  logic [4:0]       iflip, dflip;
  logic             ss_ok, norm_n, ndf_n, in_rng, imaj, dmaj;

  always_comb begin
    nf     = word[15:12];
    v      = word[PTR_W-1:0];
    flip   = v ^ cur;
    for (int k = 0; k < 5; k++) begin
      iflip[k] = flip[2*k+1];
      dflip[k] = flip[2*k];
    end
    imaj   = $countones(iflip) >= 3;
    dmaj   = $countones(dflip) >= 3;
    ss_ok  = !ss_chk_en || (word[11:10] == (ss_use_reg ? ss_reg : SS_FIXED));
    norm_n = $countones(nf ^ NDF_OFF_PAT) <= 1;
    ndf_n  = $countones(nf ^ NDF_ON_PAT) <= 1;
    in_rng = v <= MAXV;
    cls.ais_pat  = &word;
    cls.ndf_seen = ndf_n;
    cls.ndf_ok   = ndf_n && ss_ok && in_rng;
    cls.val_ok   = norm_n && ss_ok && in_rng;
    cls.inc      = norm_n && ss_ok && imaj && !dmaj;
    cls.dec      = norm_n && ss_ok && dmaj && !imaj;
    cls.val      = v;
  end
endmodule

// File: rtl/ptr_fsm.sv
module ptr_fsm
  import ptr_pkg::*;
#(
  parameter int PTR_MAX = 782,
  parameter int STEP    = 3,
  parameter int OFF_W   = 12,
  parameter int SAME_N  = 3,
  parameter int AIS_N   = 3,
  parameter int LOP_N   = 8,
  parameter int NDF_N   = 8,
  parameter int HOLD_N  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  ptr_class_t       cls,
  input  logic             ais_lop_dis,
  output ptr_state_t       st,
  output logic [PTR_W-1:0] cur,
  output logic [OFF_W-1:0] off,
  output logic             pj_ev,
  output logic             nj_ev,
  output logic             nd_ev
);
  localparam int RUN_W  = $clog2((LOP_N > NDF_N ? LOP_N : NDF_N) + 1);
  localparam int HOLD_W = $clog2(HOLD_N + 1);
  localparam logic [PTR_W-1:0] MAXV = PTR_W'(PTR_MAX);

  ptr_state_t       st_n;
  logic [PTR_W-1:0] cur_n, cand, cand_n;
  logic [RUN_W-1:0] same_r, ais_r, inv_r, ndf_r, same_n, ais_n, inv_n, ndf_n;
  logic [HOLD_W-1:0] hold, hold_n;
  logic             adj, inv_frame;

  function automatic logic [RUN_W-1:0] bump(input logic [RUN_W-1:0] r);
    return (r == '1) ? r : r + 1'b1;
  endfunction

  always_comb begin
    st_n = st; cur_n = cur; cand_n = cand; hold_n = hold;
    same_n = same_r; ais_n = ais_r; inv_n = inv_r; ndf_n = ndf_r;
    pj_ev = 1'b0; nj_ev = 1'b0; nd_ev = 1'b0;
    adj = (st == ST_NORM) && (cls.inc || cls.dec);
    inv_frame = !cls.ais_pat && !cls.ndf_ok && !adj && !cls.val_ok;
    if (ev) begin
      hold_n = (hold < HOLD_W'(HOLD_N)) ? hold + 1'b1 : hold;
      ais_n  = cls.ais_pat  ? bump(ais_r) : '0;
      ndf_n  = cls.ndf_seen ? bump(ndf_r) : '0;
      inv_n  = inv_frame    ? bump(inv_r) : '0;
      if (!adj && cls.val_ok) begin
        same_n = (cls.val == cand && same_r != '0) ? bump(same_r) : RUN_W'(1);
        cand_n = cls.val;
      end else begin
        same_n = '0;
      end
      unique case (st)
        ST_NORM: begin
          if (ais_n == RUN_W'(AIS_N)) st_n = ST_AIS;
          else if (inv_n == RUN_W'(LOP_N) || ndf_n == RUN_W'(NDF_N)) st_n = ST_LOP;
          else if (cls.ndf_ok) begin
            cur_n = cls.val; nd_ev = 1'b1; hold_n = '0;
          end else if (adj && hold == HOLD_W'(HOLD_N)) begin
            hold_n = '0;
            if (cls.inc) begin
              cur_n = (cur == MAXV) ? '0 : cur + 1'b1; pj_ev = 1'b1;
            end else begin
              cur_n = (cur == '0) ? MAXV : cur - 1'b1; nj_ev = 1'b1;
            end
          end else if (same_n == RUN_W'(SAME_N)) cur_n = cls.val;
        end
        ST_AIS: begin
          if (cls.ndf_ok) begin
            st_n = ST_NORM; cur_n = cls.val; nd_ev = 1'b1; hold_n = '0;
          end else if (same_n == RUN_W'(SAME_N)) begin
            st_n = ST_NORM; cur_n = cls.val;
          end else if (inv_n == RUN_W'(LOP_N) && !ais_lop_dis) st_n = ST_LOP;
        end
        default: begin
          if (ais_n == RUN_W'(AIS_N)) st_n = ST_AIS;
          else if (same_n == RUN_W'(SAME_N)) begin
            st_n = ST_NORM; cur_n = cls.val;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_LOP; cur <= '0; cand <= '0; off <= '0; hold <= HOLD_W'(HOLD_N);
      same_r <= '0; ais_r <= '0; inv_r <= '0; ndf_r <= '0;
    end else begin
      st <= st_n; cur <= cur_n; cand <= cand_n; hold <= hold_n;
      same_r <= same_n; ais_r <= ais_n; inv_r <= inv_n; ndf_r <= ndf_n;
      off <= OFF_W'(cur_n) * OFF_W'(STEP);
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                 q <= '0;
    else if (clr)            q <= inc ? W'(1) : '0;
    else if (inc && q != '1) q <= q + 1'b1;
  end
endmodule

// File: rtl/au4_ptr_interp.sv
module au4_ptr_interp
  import ptr_pkg::*;
#(
  parameter int PTR_MAX = 782,
  parameter int STEP    = 3,
  parameter int SAME_N  = 3,
  parameter int AIS_N   = 3,
  parameter int LOP_N   = 8,
  parameter int NDF_N   = 8,
  parameter int HOLD_N  = 3,
  parameter int CNT_W   = 8,
  parameter int OFF_W   = $clog2((PTR_MAX + 1) * STEP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             track_en,
  input  logic [7:0]       din,
  input  logic             h1_strb,
  input  logic             h2_strb,
  input  logic             pay_strb,
  input  logic             pay_sof,
  input  logic             ext_j1,
  input  logic             ss_chk_en,
  input  logic             ss_use_reg,
  input  logic [1:0]       ss_reg,
  input  logic             ais_lop_dis,
  input  logic             cnt_clr,
  output logic [OFF_W-1:0] offset,
  output logic             j1_mark,
  output logic             ais_alm,
  output logic             lop_alm,
  output logic [CNT_W-1:0] pj_cnt,
  output logic [CNT_W-1:0] nj_cnt,
  output logic [CNT_W-1:0] ndf_cnt
);
  localparam int N_CNT = 3;

  logic [7:0]       h1_q;
  ptr_class_t       cls;
  ptr_state_t       st;
  logic [PTR_W-1:0] cur;
  logic             pj_ev, nj_ev, nd_ev;
  logic [N_CNT-1:0] evs;
  logic [CNT_W-1:0] cnt_arr [N_CNT];
  logic [OFF_W-1:0] pos_q, pos_now;

  always_ff @(posedge clk) begin
    if (rst)          h1_q <= '0;
    else if (h1_strb) h1_q <= din;
  end

  ptr_classify #(.PTR_MAX(PTR_MAX)) u_cls (
    .word({h1_q, din}), .cur(cur), .ss_chk_en(ss_chk_en),
    .ss_use_reg(ss_use_reg), .ss_reg(ss_reg), .cls(cls)
  );

  ptr_fsm #(
    .PTR_MAX(PTR_MAX), .STEP(STEP), .OFF_W(OFF_W), .SAME_N(SAME_N),
    .AIS_N(AIS_N), .LOP_N(LOP_N), .NDF_N(NDF_N), .HOLD_N(HOLD_N)
  ) u_fsm (
    .clk(clk), .rst(rst), .ev(h2_strb && track_en), .cls(cls),
    .ais_lop_dis(ais_lop_dis), .st(st), .cur(cur), .off(offset),
    .pj_ev(pj_ev), .nj_ev(nj_ev), .nd_ev(nd_ev)
  );

  assign evs = {nd_ev, nj_ev, pj_ev};
  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(cnt_clr), .inc(evs[gi]), .q(cnt_arr[gi])
    );
  end
  assign pj_cnt  = cnt_arr[0];
  assign nj_cnt  = cnt_arr[1];
  assign ndf_cnt = cnt_arr[2];

  assign ais_alm = (st == ST_AIS);
  assign lop_alm = (st == ST_LOP);
  assign pos_now = pay_sof ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      j1_mark <= 1'b0;
    end else begin
      if (pay_strb) pos_q <= pos_now;
      j1_mark <= track_en ? (pay_strb && st == ST_NORM && pos_now == offset) : ext_j1;
    end
  end
endmodule

// File: rtl/au4_ptr_interp_chk.sv
module au4_ptr_interp_chk #(
  parameter int OFF_W = 12,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             track_en,
  input logic             h2_strb,
  input logic             pay_strb,
  input logic             ext_j1,
  input logic             cnt_clr,
  input logic [OFF_W-1:0] offset,
  input logic             j1_mark,
  input logic             lop_alm,
  input logic [CNT_W-1:0] pj_cnt,
  input logic [CNT_W-1:0] ndf_cnt
);
  // R13
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(h2_strb && track_en) |=> $stable(offset));

  // R6
  lop_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lop_alm) |-> $past(h2_strb));

  // R10
  pj_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (pj_cnt == '1 && !cnt_clr) |=> pj_cnt == '1);

  // R10
  ndf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (ndf_cnt == '0 || ndf_cnt == CNT_W'(1)));

  // R11
  j1_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (track_en && !pay_strb) |=> !j1_mark);

  // R12
  j1_ext_chk: assert property (@(posedge clk) disable iff (rst)
    !track_en |=> j1_mark == $past(ext_j1));
endmodule

bind au4_ptr_interp au4_ptr_interp_chk #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .track_en(track_en), .h2_strb(h2_strb),
  .pay_strb(pay_strb), .ext_j1(ext_j1), .cnt_clr(cnt_clr), .offset(offset),
  .j1_mark(j1_mark), .lop_alm(lop_alm), .pj_cnt(pj_cnt), .ndf_cnt(ndf_cnt)
);

// File: tb/au4_ptr_interp_bench.sv
module au4_ptr_interp_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, track_en, h1_strb, h2_strb, pay_strb, pay_sof, ext_j1;
  logic ss_chk_en, ss_use_reg, ais_lop_dis, cnt_clr;
  logic [1:0]  ss_reg;
  logic [7:0]  din;
  logic [11:0] offset;
  logic        j1_mark, ais_alm, lop_alm;
  logic [7:0]  pj_cnt, nj_cnt, ndf_cnt;

  au4_ptr_interp u_au4_ptr_interp (
    .clk(clk), .rst(rst), .track_en(track_en), .din(din), .h1_strb(h1_strb),
    .h2_strb(h2_strb), .pay_strb(pay_strb), .pay_sof(pay_sof), .ext_j1(ext_j1),
    .ss_chk_en(ss_chk_en), .ss_use_reg(ss_use_reg), .ss_reg(ss_reg),
    .ais_lop_dis(ais_lop_dis), .cnt_clr(cnt_clr), .offset(offset),
    .j1_mark(j1_mark), .ais_alm(ais_alm), .lop_alm(lop_alm),
    .pj_cnt(pj_cnt), .nj_cnt(nj_cnt), .ndf_cnt(ndf_cnt)
  );

  localparam logic [3:0] NN = 4'b0110, ND = 4'b1001;
  localparam logic [1:0] SSF = 2'b10;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] n, input logic [1:0] ss,
                                      input logic [9:0] v);
    return {n, ss, v};
  endfunction

  function automatic logic [9:0] inc_of(input logic [9:0] v);
    return v ^ 10'h2AA;
  endfunction

  function automatic logic [9:0] dec_of(input logic [9:0] v);
    return v ^ 10'h155;
  endfunction

  task automatic send(input logic [15:0] w, input logic clr = 1'b0);
    @(negedge clk); din = w[15:8]; h1_strb = 1'b1;
    @(negedge clk); h1_strb = 1'b0; din = w[7:0]; h2_strb = 1'b1; cnt_clr = clr;
    @(negedge clk); h2_strb = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic send_n(input logic [15:0] w, input int n);
    for (int k = 0; k < n; k++) send(w);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [9:0] v;
    logic [3:0] nv;
    int hits, hit_pos;
    void'($urandom(32'd1234));
    rst = 1; track_en = 1; din = 0; h1_strb = 0; h2_strb = 0; pay_strb = 0;
    pay_sof = 0; ext_j1 = 0; ss_chk_en = 0; ss_use_reg = 0; ss_reg = 0;
    ais_lop_dis = 0; cnt_clr = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 lop", lop_alm, 1); check("R1 ais", ais_alm, 0);
    check("R1 offset", offset, 0);
    check("R1 counters", {pj_cnt, nj_cnt, ndf_cnt}, 0);

    // R2 three identical pointers from loss of pointer
    send_n(mk(NN, SSF, 10'd100), 2);
    check("R2 two frames still lop", lop_alm, 1);
    send(mk(NN, SSF, 10'd100));
    check("R2 lop cleared", lop_alm, 0); check("R2 offset", offset, 300);

    // R4 increment, R5 hold, R4 decrement
    send(mk(NN, SSF, inc_of(10'd100)));
    check("R4 inc offset", offset, 303); check("R4 pj_cnt", pj_cnt, 1);
    send(mk(NN, SSF, inc_of(10'd101)));
    check("R5 inc ignored offset", offset, 303); check("R5 pj_cnt", pj_cnt, 1);
    send_n(mk(NN, SSF, 10'd101), 2);
    send(mk(NN, SSF, dec_of(10'd101)));
    check("R4 dec offset", offset, 300); check("R4 nj_cnt", nj_cnt, 1);

    // R3 NDF, then R5 adjustment right after an NDF
    send(mk(ND, SSF, 10'd500));
    check("R3 ndf offset", offset, 1500); check("R3 ndf_cnt", ndf_cnt, 1);
    send(mk(NN, SSF, inc_of(10'd500)));
    check("R5 inc after ndf", offset, 1500);
    send(mk(4'b1000, SSF, 10'd600));
    check("R3 ndf one bit off", offset, 1800); check("R3 ndf_cnt 2", ndf_cnt, 2);

    // R9 size-bit check modes
    ss_chk_en = 1;
    send_n(mk(NN, 2'b00, 10'd603), 3);
    check("R9 fixed SS rejects 00", offset, 1800);
    ss_use_reg = 1; ss_reg = 2'b00;
    send_n(mk(NN, 2'b00, 10'd603), 3);
    check("R9 register SS accepts 00", offset, 1809);
    ss_chk_en = 0; ss_use_reg = 0;
    send_n(mk(NN, 2'b11, 10'd611), 3);
    check("R9 check disabled", offset, 1833);

    // R6 invalid run from normal
    send_n(mk(NN, SSF, 10'd900), 7);
    check("R6 seven invalid", lop_alm, 0);
    send(mk(NN, SSF, 10'd900));
    check("R6 eight invalid", lop_alm, 1);

    // R7 AIS from loss of pointer
    send_n(16'hFFFF, 2);
    check("R7 two ais words", ais_alm, 0);
    send(16'hFFFF);
    check("R7 ais set", ais_alm, 1); check("R7 lop clear", lop_alm, 0);

    // R6 AIS to LOP, R8 suppression
    send_n(mk(NN, SSF, 10'd900), 7);
    check("R6 ais holds after seven", ais_alm, 1);
    send(mk(NN, SSF, 10'd900));
    check("R6 ais to lop", lop_alm, 1);
    send_n(16'hFFFF, 3);
    ais_lop_dis = 1;
    send_n(mk(NN, SSF, 10'd900), 9);
    check("R8 ais kept", ais_alm, 1); check("R8 no lop", lop_alm, 0);
    ais_lop_dis = 0;
    send(mk(ND, SSF, 10'd40));
    check("R3 ndf leaves ais", ais_alm, 0); check("R3 ndf in ais offset", offset, 120);
    send(mk(NN, SSF, 10'd40));

    // R6 eight consecutive NDF frames
    send_n(mk(ND, SSF, 10'd5), 7);
    check("R6 seven ndf", lop_alm, 0); check("R3 offset 15", offset, 15);
    send(mk(ND, SSF, 10'd5));
    check("R6 eight ndf", lop_alm, 1);
    send(mk(ND, SSF, 10'd77));
    check("R3 ndf ignored in lop", offset, 15);

    // R10 clear, clear with event, saturation
    send_n(mk(NN, SSF, 10'd50), 3);
    check("R2 back to normal", offset, 150);
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    check("R10 clear", ndf_cnt, 0); check("R10 clear pj", pj_cnt, 0);
    send(mk(ND, SSF, 10'd50), 1'b1);
    check("R10 clear with event", ndf_cnt, 1);
    for (int k = 0; k < 260; k++) begin
      send(mk(ND, SSF, 10'd50));
      send(mk(NN, SSF, 10'd50));
    end
    check("R10 saturate", ndf_cnt, 255);

    // R3 random NDF values and nibble variants
    v = 10'd50;
    for (int k = 0; k < 20; k++) begin
      int b;
      v = 10'($urandom % 783);
      b = int'($urandom % 5);
      nv = (b == 4) ? ND : (ND ^ (4'b0001 << b));
      send(mk(nv, SSF, v));
      check("R3 random ndf", offset, 3 * v);
      send_n(mk(NN, SSF, v), 2);
    end
    check("R2 random run normal", lop_alm, 0);

    // R11 J1 marker position
    hits = 0; hit_pos = -1;
    for (int i = 0; i < 2349; i++) begin
      @(negedge clk); pay_strb = 1; pay_sof = (i == 0);
      @(posedge clk); #2;
      if (j1_mark) begin hits++; hit_pos = i; end
    end
    @(negedge clk); pay_strb = 0; pay_sof = 0;
    check("R11 one marker", hits, 1); check("R11 marker position", hit_pos, 3 * v);

    // R12 untracked mode
    track_en = 0;
    @(negedge clk); ext_j1 = 1;
    @(posedge clk); #2; check("R12 ext high", j1_mark, 1);
    @(negedge clk); ext_j1 = 0;
    @(posedge clk); #2; check("R12 ext low", j1_mark, 0);
    send_n(mk(NN, SSF, (v == 10'd100) ? 10'd101 : 10'd100), 3);
    check("R12 offset frozen", offset, 3 * v);

    done = 1;
    summary();
    $finish;
  end
endmodule